// File: doc/BRIEF.md
# Four-Level Nested Interrupt Controller

This block picks which of thirteen interrupt requests a small 8-bit processor core takes next. Each source has its own enable bit, and one global enable gates all of them. Each source also has one of four priority levels, built from one bit in a low-priority register and one bit in a high-priority register. Arbitration happens only when the core marks an instruction boundary. The block then issues a one-cycle take strobe with the winning source index. It keeps a mask of the priority levels that are in service, so a running handler can be displaced only by a request of strictly higher level. A return pulse from the core retires the innermost handler.

Two request sources are external pins, active low. Each pin is either level-sensitive or edge-sensitive, and the edge-sensitive form latches a falling edge seen across two successive samples. While the core sleeps, an enabled external request raises a wake output.

Source index 0 is external pin 0, index 1 is external pin 1, and index k (k from 2 to 12) is `src_req[k]`. Configuration is written through `cfg_we`/`cfg_addr`/`cfg_wdata`. Writes take effect at the clock edge.

Top module: `irq_nest_ctrl`

## Requirements
- R1: While the global enable (bit 0 written at `cfg_addr` 1) is 0, no take strobe occurs, whatever requests are pending.
- R2: A source whose enable bit (bit k written at `cfg_addr` 0) is 0 is never taken.
- R3: The level of source k is {high bit k (`cfg_addr` 3), low bit k (`cfg_addr` 2)}, from 0 to 3. Among eligible pending requests, the highest level wins.
- R4: Among eligible requests of the same level, the lowest source index wins.
- R5: When `boundary` is high and a request is eligible, `take` is high for exactly the next cycle and carries the winner in `take_idx`. Without `boundary`, no take occurs.
- R6: A take sets bit L of `active_mask`, where L is the winner's level. A `reti` pulse clears the highest set bit of `active_mask`.
- R7: While `active_mask` is nonzero, a request is eligible only if its level is strictly above the highest set bit. Requests of equal or lower level wait.
- R8: While bit 3 of `active_mask` is set, no source is taken.
- R9: With mode bit j (`cfg_addr` 4) set to 1, pin j is edge-sensitive. A high sample followed by a low sample sets its request flag. The flag is cleared when source j is taken, and a pin held low does not set it again.
- R10: With mode bit j set to 0, the request of pin j equals the sampled low state of the pin, with no latching.
- R11: `wake` is high while `core_asleep` is high and an external source with its own enable bit set is requesting.
- R12: Reset clears all enables, levels, modes, flags and `active_mask`, so no take occurs until software enables a source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | 0 enables, 1 global enable, 2 low level bits, 3 high level bits, 4 pin modes |
| cfg_wdata | input | 13 | Configuration write data |
| src_req | input | 11 | Internal requests for sources 2 to 12 (bits 12:2) |
| ext_n | input | 2 | External interrupt pins, active low |
| boundary | input | 1 | Instruction boundary: arbitrate this cycle |
| reti | input | 1 | Return from the current handler |
| core_asleep | input | 1 | Core is idle or powered down |
| take | output | 1 | One-cycle interrupt take strobe |
| take_idx | output | 4 | Index of the source being taken |
| active_mask | output | 4 | Priority levels in service, one bit per level |
| wake | output | 1 | Wake request to a sleeping core |

## Verification
The hardest state to reach from the ports is a level-3 handler running on top of handlers at levels 1 and 2 while requests of every level are still pending. Only that state shows that nesting blocks everything and that a return exposes the correct level. The stimulus builds the stack one step at a time. It raises a level-1 source and takes it, then adds a level-2 and a level-3 source at successive boundaries, and it keeps all earlier requests asserted. It then unwinds with return pulses and checks the mask and any retake after each pulse.

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl #(
  parameter int NSRC = 13,
  parameter int IW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [2:0]      cfg_addr,
  input  logic [NSRC-1:0] cfg_wdata,
  input  logic [NSRC-1:2] src_req,
  input  logic [1:0]      ext_n,
  input  logic            boundary,
  input  logic            reti,
  input  logic            core_asleep,
  output logic            take,
  output logic [IW-1:0]   take_idx,
  output logic [3:0]      active_mask,
  output logic            wake
);
  logic [NSRC-1:0] en_q, plo_q, phi_q;
  logic            gen_q;
  logic [1:0]      mode_q, s1_q, s2_q, eflag_q;
  logic [3:0]      act_q, act_next;
  logic            take_q;
  logic [IW-1:0]   idx_q;

  wire [1:0]      ext_req = (mode_q & eflag_q) | (~mode_q & ~s1_q);
  wire [NSRC-1:0] pend    = {src_req, ext_req} & en_q & {NSRC{gen_q}};

  logic       cur_valid;
  logic [1:0] cur_lvl;
  assign cur_valid = |act_q;
  assign cur_lvl   = act_q[3] ? 2'd3 : act_q[2] ? 2'd2 : act_q[1] ? 2'd1 : 2'd0;

  logic          found;
  logic [IW-1:0] best_idx;
  logic [1:0]    best_lvl, lv;
  always_comb begin
    found = 1'b0;
    best_idx = '0;
    best_lvl = '0;
    lv = '0;
    for (int i = 0; i < NSRC; i++) begin
      lv = {phi_q[i], plo_q[i]};
      if (pend[i] && (!cur_valid || lv > cur_lvl) && (!found || lv > best_lvl)) begin
        found = 1'b1;
        best_idx = IW'(i);
        best_lvl = lv;
      end
    end
  end

  wire grant = boundary & found;

  always_comb begin
    act_next = act_q;
    if (reti && cur_valid) act_next[cur_lvl] = 1'b0;
    if (grant) act_next[best_lvl] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0; plo_q <= '0; phi_q <= '0; gen_q <= 1'b0; mode_q <= '0;
      s1_q <= 2'b11; s2_q <= 2'b11; eflag_q <= '0;
      act_q <= '0; take_q <= 1'b0; idx_q <= '0;
    end else begin
      if (cfg_we) begin
        case (cfg_addr)
          3'd0: en_q <= cfg_wdata;
          3'd1: gen_q <= cfg_wdata[0];
          3'd2: plo_q <= cfg_wdata;
          3'd3: phi_q <= cfg_wdata;
          3'd4: mode_q <= cfg_wdata[1:0];
          default: ;
        endcase
      end
      s1_q <= ext_n;
      s2_q <= s1_q;
      for (int j = 0; j < 2; j++) begin
        if (grant && best_idx == IW'(j)) eflag_q[j] <= 1'b0;
        if (s2_q[j] && !s1_q[j]) eflag_q[j] <= 1'b1;
      end
      take_q <= grant;
      if (grant) idx_q <= best_idx;
      act_q <= act_next;
    end
  end

  assign take        = take_q;
  assign take_idx    = idx_q;
  assign active_mask = act_q;
  assign wake        = core_asleep & |(ext_req & en_q[1:0]);
endmodule

// File: rtl/irq_nest_ctrl_chk.sv
module irq_nest_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       boundary,
  input logic       core_asleep,
  input logic       take,
  input logic [3:0] take_idx,
  input logic [3:0] active_mask,
  input logic       wake,
  input logic       gen_q
);
  // R1
  glob_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) take |-> $past(gen_q));
  // R5
  take_needs_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n) take |-> $past(boundary));
  // R5
  take_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n) take |-> take_idx < 4'd13);
  // R6
  mask_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_mask & ~$past(active_mask)) != 4'd0 |-> take);
  // R8
  top_level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) take |-> !$past(active_mask[3]));
  // R11
  wake_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n) wake |-> core_asleep);
endmodule

bind irq_nest_ctrl irq_nest_ctrl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .boundary(boundary), .core_asleep(core_asleep),
  .take(take), .take_idx(take_idx), .active_mask(active_mask), .wake(wake), .gen_q(gen_q)
);

// File: tb/test_irq_nest_ctrl.sv
`timescale 1ns/1ps
module test_irq_nest_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [12:0] cfg_wdata = '0;
  logic [12:2] src_req = '0;
  logic [1:0]  ext_n = 2'b11;
  logic        boundary = 1'b0, reti = 1'b0, core_asleep = 1'b0;
  logic        take, wake;
  logic [3:0]  take_idx, active_mask;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  irq_nest_ctrl i_irq_nest_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .src_req(src_req), .ext_n(ext_n), .boundary(boundary), .reti(reti),
    .core_asleep(core_asleep), .take(take), .take_idx(take_idx),
    .active_mask(active_mask), .wake(wake)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; src_req = '0; ext_n = 2'b11; boundary = 0; reti = 0; core_asleep = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [12:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic arb(input string tag, input bit exp_take, input int exp_idx, input int exp_mask);
    boundary = 1'b1;
    @(negedge clk);
    boundary = 1'b0;
    chk({tag, " take"}, take, exp_take);
    if (exp_take) chk({tag, " idx"}, take_idx, exp_idx);
    chk({tag, " mask"}, active_mask, exp_mask);
    @(negedge clk);
    chk({tag, " strobe one cycle R5"}, take, 0);
  endtask

  task automatic ret(input string tag, input int exp_mask);
    reti = 1'b1;
    @(negedge clk);
    reti = 1'b0;
    chk({tag, " mask after reti"}, active_mask, exp_mask);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R12 take", take, 0);
    chk("R12 mask", active_mask, 0);
    chk("R12 wake", wake, 0);
    src_req = '1; ext_n = 2'b00;
    idle(3);
    arb("R12 nothing enabled", 0, 0, 0);
  endtask

  task automatic t_enables();
    do_reset();
    wr(0, 13'h1FFF);
    src_req[4] = 1'b1;
    arb("R1 global off", 0, 0, 0);
    wr(1, 13'h1);
    wr(0, 13'h1FFF & ~13'h0010);
    arb("R2 source off", 0, 0, 0);
    wr(0, 13'h1FFF);
    boundary = 1'b0;
    idle(3);
    chk("R5 no boundary", take, 0);
    arb("R2 source on", 1, 4, 1);
  endtask

  task automatic t_order();
    do_reset();
    wr(0, 13'h1FFF); wr(1, 1);
    src_req[3] = 1; src_req[9] = 1; src_req[12] = 1;
    arb("R4 tie lowest index", 1, 3, 1);
    ret("R6", 0);
    wr(3, 13'h0200); wr(2, 13'h1000);
    arb("R3 higher level wins", 1, 9, 4);
  endtask

  task automatic t_nest();
    do_reset();
    wr(0, 13'h1FFF); wr(1, 1);
    wr(2, 13'h0160); wr(3, 13'h0180);
    src_req[5] = 1;
    arb("R6 first take lvl1", 1, 5, 4'b0010);
    src_req[6] = 1; src_req[4] = 1;
    arb("R7 equal and lower wait", 0, 0, 4'b0010);
    src_req[7] = 1;
    arb("R7 higher preempts", 1, 7, 4'b0110);
    src_req[8] = 1;
    arb("R7 top level preempts", 1, 8, 4'b1110);
    arb("R8 top level not preempted", 0, 0, 4'b1110);
    ret("R6 pop top", 4'b0110);
    arb("R7 lvl3 retaken", 1, 8, 4'b1110);
    ret("R6 pop 3", 4'b0110);
    src_req = '0;
    ret("R6 pop 2", 4'b0010);
    ret("R6 pop 1", 4'b0000);
  endtask

  task automatic t_edge();
    do_reset();
    wr(0, 13'h0003); wr(1, 1); wr(4, 13'h0001);
    ext_n[0] = 1'b0;
    idle(3);
    arb("R9 falling edge taken", 1, 0, 1);
    ret("R9", 0);
    idle(2);
    arb("R9 flag cleared held low", 0, 0, 0);
    ext_n[0] = 1'b1; idle(3);
    ext_n[0] = 1'b0; idle(3);
    ext_n[0] = 1'b1; idle(3);
    arb("R9 latched short pulse", 1, 0, 1);
  endtask

  task automatic t_level();
    do_reset();
    wr(0, 13'h0003); wr(1, 1);
    ext_n[1] = 1'b0;
    idle(2);
    arb("R10 level low taken", 1, 1, 1);
    ret("R10", 0);
    arb("R10 still low retaken", 1, 1, 1);
    ret("R10", 0);
    ext_n[1] = 1'b1;
    idle(2);
    arb("R10 released no latch", 0, 0, 0);
  endtask

  task automatic t_wake();
    do_reset();
    core_asleep = 1'b1;
    wr(0, 13'h0002);
    ext_n[1] = 1'b0;
    idle(2);
    chk("R11 wake enabled pin", wake, 1);
    ext_n[1] = 1'b1;
    idle(2);
    chk("R11 wake drops", wake, 0);
    ext_n[0] = 1'b0;
    idle(2);
    chk("R11 disabled pin no wake", wake, 0);
    core_asleep = 1'b0;
    ext_n = 2'b00;
    idle(2);
    chk("R11 awake no wake", wake, 0);
  endtask

  initial begin
    t_reset();
    t_enables();
    t_order();
    t_nest();
    t_edge();
    t_level();
    t_wake();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule